// File: doc/BRIEF.md
# DMA Transfer Descriptor Splitter

This block turns one transfer request into the queue descriptors that a line-oriented PCIe DMA engine consumes. A request gives a host address, a local address, a byte length, a direction and a format select. One clock later the block presents one or two 256-bit descriptors, a descriptor count and an error flag, all qualified by a one-cycle valid strobe. It does not move any data. It only works out the line geometry and packs the descriptor fields.

A transfer longer than a single line is split. The first descriptor is a strided multi-line descriptor made of whole lines. When bytes are left over, a second single-line descriptor carries them, and only that last descriptor asks for a completion interrupt. Two descriptor encodings are supported and chosen per request. Format B counts sizes in bytes, supports 64-bit host addressing and has 15-bit pitch fields. Format A counts line sizes in 16-byte units and pitches in 8-byte units, and it carries ID and direction flags in the pitch word.

Top module: `xfer_desc_split`

## Requirements
- R1: Each descriptor is 256 bits: bits 63:0 hold the host address, 127:64 the pitch word, 191:128 the command word, and 255:192 are always zero. A zero-length request produces two all-zero descriptors.
- R2: Every cycle with `req_valid` high yields `out_valid` high on the following cycle, carrying that request's result. `out_valid` is low in the cycle after one with `req_valid` low.
- R3: A request of length zero gives `out_err`=1, `out_count`=0 and two all-zero descriptors.
- R4: In format B (`req_fmt`=1), a length up to 0x7FFF gives one descriptor with the following fields. Command bits 14:0 equal the length and bits 27:16 equal 1. Pitch bits 46:32 (host pitch) and 62:48 (local pitch) are 1. Pitch bits 30:0 are local address bits 30:0.
- R5: In format B, a length above 0x7FFF uses a line of 0x7000 bytes. The first descriptor has line count length/0x7000, line size 0x7000, and host and local pitch 0x7000.
- R6: In either format, when bytes remain after the whole lines, a second descriptor is produced. Its host and local addresses are both advanced by lines × line unit. It has line count 1, both pitches 1, and a line size equal to the remainder (bytes in format B, 16-byte units in format A).
- R7: The completion interrupt appears only on the last descriptor. In format B this is command bit 37. In format A it is command bits 31 and 15. These bits are set on a sole descriptor, and when two descriptors are produced they are clear on the first and set on the second.
- R8: In format B, command bit 32 equals the upstream flag. Command bit 40 is set when host address bits 63:32, or bits 63:32 of host address + length, are non-zero. Both bits are identical on both descriptors.
- R9: In format A (`req_fmt`=0), a length up to 0x7FF0 gives one descriptor with the following fields. Command bits 14:4 hold length/16 and bits 27:16 hold 1. Pitch bits 46:35 and 62:51 hold 1. Pitch bits 29:4 are local address bits 29:4. Pitch bit 31 is the upstream flag. Pitch bit 0 and command bit 1 are always 1.
- R10: In format A, a length above 0x7FF0 uses a line of 0x7FF0 bytes. The first descriptor has line count length/0x7FF0, size field 0x7FF and pitch fields 0xFFE. A second descriptor exists only if the leftover, counted in whole 16-byte units, is non-zero.
- R11: For a non-zero length, `out_count` is 1 or 2. When it is 1, `out_desc1` is all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, one request per cycle |
| req_fmt | input | 1 | Descriptor format: 0 = A, 1 = B |
| req_upstream | input | 1 | 1 = local to host, 0 = host to local |
| req_host_addr | input | 64 | Host-side start address |
| req_local_addr | input | LADDR_W (32) | Local-side start address |
| req_len | input | LEN_W (24) | Transfer length in bytes |
| out_valid | output | 1 | One-cycle result strobe |
| out_err | output | 1 | Zero-length request flag |
| out_count | output | 2 | Number of descriptors (0, 1 or 2) |
| out_desc0 | output | 256 | First descriptor |
| out_desc1 | output | 256 | Second descriptor, or zero |

## Verification
The bench sweeps each format and direction across lengths that sit on and next to the single-line limits, on exact multiples of the line unit, and on format-A leftovers of fewer than 16 bytes. A design with an off-by-one limit would split a length that fits in one line, or fail to split one that does not. A design that mishandled the sub-16-byte leftover would emit an empty second descriptor. Host addresses just below the 4 GiB boundary test the 64-bit flag: a design that looked only at the start address would clear that flag when the end of the transfer crosses the boundary. Back-to-back requests and local addresses that wrap expose results mixed up between requests and wrong advance arithmetic on the remainder descriptor.

// File: rtl/xds_pkg.sv
package xds_pkg;

  typedef enum logic { FMT_A = 1'b0, FMT_B = 1'b1 } fmt_e;

  // rsvd is the most significant word, host the least significant
  typedef struct packed {
    logic [63:0] rsvd;
    logic [63:0] cmd;
    logic [63:0] pitch;
    logic [63:0] host;
  } desc_t;

  localparam int DESC_W = $bits(desc_t);

  // format B geometry (bytes)
  localparam logic [63:0] B_SIZE_MAX  = 64'h7FFF;
  localparam logic [63:0] B_UNIT      = 64'h7000;
  localparam logic [63:0] B_ADDR_MASK = 64'h7FFF_FFFF;
  localparam int          B_HP_SH     = 32;
  localparam int          B_LP_SH     = 48;
  localparam int          B_UP_BIT    = 32;
  localparam int          B_IRQ_BIT   = 37;
  localparam int          B_WIDE_BIT  = 40;

  // format A geometry
  localparam logic [63:0] A_UNIT      = 64'h7FF0;
  localparam logic [63:0] A_ADDR_MASK = 64'h3FFF_FFF0;
  localparam int          A_HP_SH     = 35;
  localparam int          A_LP_SH     = 51;
  localparam int          A_SIZE_SH   = 4;
  localparam int          A_UP_BIT    = 31;
  localparam int          A_IRQE_BIT  = 31;
  localparam int          A_IRQL_BIT  = 15;
  localparam int          A_PID_BIT   = 0;
  localparam int          A_CID_BIT   = 1;

  localparam int          LINES_SH    = 16;
  localparam logic [63:0] MASK11      = 64'h7FF;
  localparam logic [63:0] MASK12      = 64'hFFF;
  localparam logic [63:0] MASK15      = 64'h7FFF;

  function automatic logic [63:0] place(input logic [63:0] v, input logic [63:0] mask, input int sh);
    return (v & mask) << sh;
  endfunction

endpackage

// File: rtl/xds_line_split.sv
module xds_line_split
  import xds_pkg::*;
#(
  parameter int LEN_W = 24
) (
  input  fmt_e             fmt,
  input  logic [LEN_W-1:0] len,
  output logic             multi,
  output logic             has_rem,
  output logic [LEN_W-1:0] lines,
  output logic [LEN_W-1:0] total,
  output logic [LEN_W-1:0] rem_field
);

  localparam logic [LEN_W-1:0] UNIT_A = LEN_W'(A_UNIT);
  localparam logic [LEN_W-1:0] UNIT_B = LEN_W'(B_UNIT);
  localparam logic [LEN_W-1:0] MAX_A  = LEN_W'(A_UNIT);
  localparam logic [LEN_W-1:0] MAX_B  = LEN_W'(B_SIZE_MAX);

  logic [LEN_W-1:0] lines_a, lines_b;

  assign lines_a = len / UNIT_A;
  assign lines_b = len / UNIT_B;

  always_comb begin
    if (fmt == FMT_B) begin
      multi     = len > MAX_B;
      lines     = lines_b;
      total     = lines_b * UNIT_B;
      rem_field = len - total;
    end else begin
      multi     = len > MAX_A;
      lines     = lines_a;
      total     = lines_a * UNIT_A;
      rem_field = (len - total) >> 4;
    end
    has_rem = multi && (rem_field != '0);
  end

endmodule

// File: rtl/xds_pack_b.sv
module xds_pack_b
  import xds_pkg::*;
#(
  parameter int LEN_W   = 24,
  parameter int LADDR_W = 32
) (
  input  logic [63:0]        host_addr,
  input  logic [LADDR_W-1:0] local_addr,
  input  logic [LEN_W-1:0]   len,
  input  logic               upstream,
  input  logic               multi,
  input  logic               has_rem,
  input  logic [LEN_W-1:0]   lines,
  input  logic [LEN_W-1:0]   total,
  input  logic [LEN_W-1:0]   rem_field,
  output desc_t              d0,
  output desc_t              d1
);

  logic [63:0]        host_end;
  logic               wide;
  logic [63:0]        cmd_base;
  logic [LADDR_W-1:0] local_rem;

  always_comb begin
    host_end  = host_addr + 64'(len);
    wide      = ((host_addr >> 32) != 64'd0) || ((host_end >> 32) != 64'd0);
    cmd_base  = 64'(upstream) << B_UP_BIT | 64'(wide) << B_WIDE_BIT;
    local_rem = local_addr + LADDR_W'(total);
    d0 = '0;
    d1 = '0;

    d0.host = host_addr;
    d0.cmd  = cmd_base | 64'(!has_rem) << B_IRQ_BIT;
    if (multi) begin
      d0.pitch = (64'(local_addr) & B_ADDR_MASK) | place(B_UNIT, MASK15, B_HP_SH)
               | place(B_UNIT, MASK15, B_LP_SH);
      d0.cmd   = d0.cmd | place(64'(lines), MASK12, LINES_SH) | place(B_UNIT, MASK15, 0);
    end else begin
      d0.pitch = (64'(local_addr) & B_ADDR_MASK) | place(64'd1, MASK15, B_HP_SH)
               | place(64'd1, MASK15, B_LP_SH);
      d0.cmd   = d0.cmd | place(64'd1, MASK12, LINES_SH) | place(64'(len), MASK15, 0);
    end

    if (has_rem) begin
      d1.host  = host_addr + 64'(total);
      d1.pitch = (64'(local_rem) & B_ADDR_MASK) | place(64'd1, MASK15, B_HP_SH)
               | place(64'd1, MASK15, B_LP_SH);
      d1.cmd   = cmd_base | 64'd1 << B_IRQ_BIT | place(64'd1, MASK12, LINES_SH)
               | place(64'(rem_field), MASK15, 0);
    end
  end

endmodule

// File: rtl/xds_pack_a.sv
module xds_pack_a
  import xds_pkg::*;
#(
  parameter int LEN_W   = 24,
  parameter int LADDR_W = 32
) (
  input  logic [63:0]        host_addr,
  input  logic [LADDR_W-1:0] local_addr,
  input  logic [LEN_W-1:0]   len,
  input  logic               upstream,
  input  logic               multi,
  input  logic               has_rem,
  input  logic [LEN_W-1:0]   lines,
  input  logic [LEN_W-1:0]   total,
  input  logic [LEN_W-1:0]   rem_field,
  output desc_t              d0,
  output desc_t              d1
);

  localparam logic [63:0] PITCH_LONG = A_UNIT >> 3;
  localparam logic [63:0] SIZE_LONG  = A_UNIT >> 4;

  logic [63:0]        pitch_flags;
  logic [63:0]        cmd_flags;
  logic [63:0]        irq_bits;
  logic [LADDR_W-1:0] local_rem;

  always_comb begin
    pitch_flags = 64'd1 << A_PID_BIT | 64'(upstream) << A_UP_BIT;
    cmd_flags   = 64'd1 << A_CID_BIT;
    irq_bits    = 64'd1 << A_IRQE_BIT | 64'd1 << A_IRQL_BIT;
    local_rem   = local_addr + LADDR_W'(total);
    d0 = '0;
    d1 = '0;

    d0.host = host_addr;
    d0.cmd  = cmd_flags | (has_rem ? 64'd0 : irq_bits);
    if (multi) begin
      d0.pitch = pitch_flags | (64'(local_addr) & A_ADDR_MASK)
               | place(PITCH_LONG, MASK12, A_HP_SH) | place(PITCH_LONG, MASK12, A_LP_SH);
      d0.cmd   = d0.cmd | place(64'(lines), MASK12, LINES_SH) | place(SIZE_LONG, MASK11, A_SIZE_SH);
    end else begin
      d0.pitch = pitch_flags | (64'(local_addr) & A_ADDR_MASK)
               | place(64'd1, MASK12, A_HP_SH) | place(64'd1, MASK12, A_LP_SH);
      d0.cmd   = d0.cmd | place(64'd1, MASK12, LINES_SH)
               | place(64'(len) >> 4, MASK11, A_SIZE_SH);
    end

    if (has_rem) begin
      d1.host  = host_addr + 64'(total);
      d1.pitch = pitch_flags | (64'(local_rem) & A_ADDR_MASK)
               | place(64'd1, MASK12, A_HP_SH) | place(64'd1, MASK12, A_LP_SH);
      d1.cmd   = cmd_flags | irq_bits | place(64'd1, MASK12, LINES_SH)
               | place(64'(rem_field), MASK11, A_SIZE_SH);
    end
  end

endmodule

// File: rtl/xfer_desc_split.sv
module xfer_desc_split
  import xds_pkg::*;
#(
  parameter int LEN_W   = 24,
  parameter int LADDR_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic               req_fmt,
  input  logic               req_upstream,
  input  logic [63:0]        req_host_addr,
  input  logic [LADDR_W-1:0] req_local_addr,
  input  logic [LEN_W-1:0]   req_len,
  output logic               out_valid,
  output logic               out_err,
  output logic [1:0]         out_count,
  output logic [DESC_W-1:0]  out_desc0,
  output logic [DESC_W-1:0]  out_desc1
);

  localparam int CMD_LSB = 128;

  fmt_e             fmt;
  logic             zero_len;
  logic             split_multi, split_two;
  logic [LEN_W-1:0] split_lines, split_total, split_rem;
  desc_t            a_d0, a_d1, b_d0, b_d1, sel_d0, sel_d1;
  fmt_e             fmt_q;

  assign fmt      = fmt_e'(req_fmt);
  assign zero_len = (req_len == '0);

  xds_line_split #(.LEN_W(LEN_W)) split_i (
    .fmt(fmt), .len(req_len),
    .multi(split_multi), .has_rem(split_two), .lines(split_lines),
    .total(split_total), .rem_field(split_rem)
  );

  xds_pack_a #(.LEN_W(LEN_W), .LADDR_W(LADDR_W)) pack_a_i (
    .host_addr(req_host_addr), .local_addr(req_local_addr), .len(req_len),
    .upstream(req_upstream), .multi(split_multi), .has_rem(split_two),
    .lines(split_lines), .total(split_total), .rem_field(split_rem),
    .d0(a_d0), .d1(a_d1)
  );

  xds_pack_b #(.LEN_W(LEN_W), .LADDR_W(LADDR_W)) pack_b_i (
    .host_addr(req_host_addr), .local_addr(req_local_addr), .len(req_len),
    .upstream(req_upstream), .multi(split_multi), .has_rem(split_two),
    .lines(split_lines), .total(split_total), .rem_field(split_rem),
    .d0(b_d0), .d1(b_d1)
  );

  assign sel_d0 = (fmt == FMT_B) ? b_d0 : a_d0;
  assign sel_d1 = (fmt == FMT_B) ? b_d1 : a_d1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_err   <= 1'b0;
      out_count <= 2'd0;
      out_desc0 <= '0;
      out_desc1 <= '0;
      fmt_q     <= FMT_A;
    end else begin
      out_valid <= req_valid;
      if (req_valid) begin
        fmt_q <= fmt;
        if (zero_len) begin
          out_err   <= 1'b1;
          out_count <= 2'd0;
          out_desc0 <= '0;
          out_desc1 <= '0;
        end else begin
          out_err   <= 1'b0;
          out_count <= split_two ? 2'd2 : 2'd1;
          out_desc0 <= sel_d0;
          out_desc1 <= split_two ? sel_d1 : '0;
        end
      end
    end
  end

  // R2: result strobe follows each request by exactly one cycle
  assert_valid_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> out_valid);
  assert_valid_drops_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !out_valid);

  // R3: zero length gives an error and no descriptors
  assert_zero_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_len == '0) |=> (out_err && out_count == 2'd0 &&
                                      out_desc0 == '0 && out_desc1 == '0));

  // R11: count range and idle second descriptor
  assert_count_range_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_err) |-> (out_count == 2'd1 || out_count == 2'd2));
  assert_desc1_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_count == 2'd1) |-> (out_desc1 == '0));

  // R1: reserved words stay zero
  assert_rsvd_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_desc0[255:192] == 64'd0 && out_desc1[255:192] == 64'd0));

  // R7: interrupt request only on the last descriptor
  assert_irq_last_b_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_count == 2'd2 && fmt_q == FMT_B) |->
      (!out_desc0[CMD_LSB+B_IRQ_BIT] && out_desc1[CMD_LSB+B_IRQ_BIT]));
  assert_irq_last_a_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_count == 2'd2 && fmt_q == FMT_A) |->
      (!out_desc0[CMD_LSB+A_IRQE_BIT] && out_desc1[CMD_LSB+A_IRQE_BIT]));

  // R8: direction bit in format B tracks the request
  assert_dir_b_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_fmt && req_len != '0) |=>
      (out_desc0[CMD_LSB+B_UP_BIT] == $past(req_upstream)));

endmodule

// File: tb/xfer_desc_split_tb_top.sv
module xfer_desc_split_tb_top;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         req_valid = 1'b0;
  logic         req_fmt = 1'b0;
  logic         req_upstream = 1'b0;
  logic [63:0]  req_host_addr = '0;
  logic [31:0]  req_local_addr = '0;
  logic [23:0]  req_len = '0;
  logic         out_valid, out_err;
  logic [1:0]   out_count;
  logic [255:0] out_desc0, out_desc1;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  xfer_desc_split dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_fmt(req_fmt),
    .req_upstream(req_upstream), .req_host_addr(req_host_addr),
    .req_local_addr(req_local_addr), .req_len(req_len),
    .out_valid(out_valid), .out_err(out_err), .out_count(out_count),
    .out_desc0(out_desc0), .out_desc1(out_desc1)
  );

  task automatic chk(input string tag, input logic [255:0] act, input logic [255:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // independent model: line count by repeated subtraction, fields by shifting
  task automatic model(input bit fmtb, input bit up, input logic [63:0] h,
                       input logic [31:0] la, input int unsigned len,
                       output int cnt, output bit err,
                       output logic [255:0] e0, output logic [255:0] e1,
                       output bit long_req);
    int unsigned unit, limit, n, tot, r, remv;
    logic [63:0] endp, cmd, pit, p, sz, la2;
    bit wide;
    e0 = '0; e1 = '0; cnt = 0; err = 0; long_req = 0;
    if (len == 0) begin err = 1; return; end
    unit  = fmtb ? 32'h7000 : 32'h7FF0;
    limit = fmtb ? 32'h7FFF : 32'h7FF0;
    n = 1; tot = 0; remv = 0;
    if (len > limit) begin
      long_req = 1; n = 0; r = len;
      while (r >= unit) begin r -= unit; n++; tot += unit; end
      remv = fmtb ? r : (r / 16);
    end
    cnt = (remv != 0) ? 2 : 1;
    endp = h + 64'(len);
    wide = (h[63:32] != 0) || (endp[63:32] != 0);
    la2  = 64'(la + tot);
    if (fmtb) begin
      p   = long_req ? 64'h7000 : 64'd1;
      sz  = long_req ? 64'h7000 : 64'(len);
      cmd = (64'(up) << 32) | (64'(wide) << 40);
      pit = (64'(la) & 64'h7FFF_FFFF) | (p << 32) | (p << 48);
      e0 = {64'd0, cmd | (64'(n) << 16) | sz | (64'(cnt == 1) << 37), pit, h};
      if (cnt == 2)
        e1 = {64'd0, cmd | (64'd1 << 16) | 64'(remv) | (64'd1 << 37),
              (la2 & 64'h7FFF_FFFF) | (64'd1 << 32) | (64'd1 << 48), h + 64'(tot)};
    end else begin
      p   = long_req ? 64'd4094 : 64'd1;
      sz  = long_req ? 64'd2047 : 64'(len / 16);
      pit = 64'd1 | (64'(up) << 31) | (64'(la) & 64'h3FFF_FFF0) | (p << 35) | (p << 51);
      cmd = 64'd2 | (64'(n) << 16) | (sz << 4);
      if (cnt == 1) cmd = cmd | (64'd1 << 31) | (64'd1 << 15);
      e0 = {64'd0, cmd, pit, h};
      if (cnt == 2)
        e1 = {64'd0, 64'd2 | (64'd1 << 16) | (64'(remv) << 4) | (64'd1 << 31) | (64'd1 << 15),
              64'd1 | (64'(up) << 31) | (la2 & 64'h3FFF_FFF0) | (64'd1 << 35) | (64'd1 << 51),
              h + 64'(tot)};
    end
  endtask

  task automatic drive(input bit fmtb, input bit up, input logic [63:0] h,
                       input logic [31:0] la, input int unsigned len);
    req_valid = 1'b1; req_fmt = fmtb; req_upstream = up;
    req_host_addr = h; req_local_addr = la; req_len = 24'(len);
  endtask

  task automatic check_out(input bit fmtb, input bit up, input logic [63:0] h,
                           input logic [31:0] la, input int unsigned len);
    int cnt; bit err, lng;
    logic [255:0] e0, e1;
    string t0, t1;
    model(fmtb, up, h, la, len, cnt, err, e0, e1, lng);
    chk("R2 out_valid", 256'(out_valid), 256'd1);
    if (err) begin
      chk("R3 err", 256'(out_err), 256'd1);
      chk("R3 count", 256'(out_count), 256'd0);
      chk("R3 desc0", out_desc0, '0);
      chk("R3 desc1", out_desc1, '0);
      return;
    end
    chk("R11 count", 256'({out_err, out_count}), 256'(cnt));
    if (fmtb) t0 = lng ? "R5 desc0" : "R4 desc0";
    else      t0 = lng ? "R10 desc0" : "R9 desc0";
    t1 = (cnt == 2) ? (fmtb ? "R6 desc1" : "R6 R10 desc1") : "R11 desc1";
    chk(t0, out_desc0, e0);
    chk(t1, out_desc1, e1);
    chk("R1 reserved", 256'({out_desc0[255:192], out_desc1[255:192]}), 256'd0);
    if (fmtb) begin
      chk("R7 irq b", 256'({out_desc0[165], out_desc1[165]}), 256'({e0[165], e1[165]}));
      chk("R8 dir/wide", 256'({out_desc0[160], out_desc0[168], out_desc1[160], out_desc1[168]}),
          256'({e0[160], e0[168], e1[160], e1[168]}));
    end else begin
      chk("R7 irq a", 256'({out_desc0[159], out_desc0[143], out_desc1[159], out_desc1[143]}),
          256'({e0[159], e0[143], e1[159], e1[143]}));
    end
  endtask

  task automatic run(input bit fmtb, input bit up, input logic [63:0] h,
                     input logic [31:0] la, input int unsigned len);
    @(negedge clk);
    drive(fmtb, up, h, la, len);
    @(negedge clk);
    req_valid = 1'b0;
    check_out(fmtb, up, h, la, len);
    @(negedge clk);
    chk("R2 strobe drop", 256'(out_valid), 256'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_fail++; n_checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    int unsigned lens[22];
    logic [63:0] hosts[3];
    logic [31:0] locs[2];
    lens = '{0, 1, 15, 16, 17, 32'h6FFF, 32'h7000, 32'h7001, 32'h7FEF, 32'h7FF0,
             32'h7FF5, 32'h7FFF, 32'h8000, 32'h8005, 32'hE000, 32'hE001, 32'hFFE0,
             32'hFFE4, 32'hFFF0, 32'h15000, 32'h3FFF00, 32'hFFFFFF};
    hosts = '{64'h0000_0000_1000_0000, 64'h0000_0000_FFFF_F000, 64'h0000_0002_0000_0040};
    locs  = '{32'h8765_4320, 32'hFFFF_FFF0};

    repeat (3) @(negedge clk);
    chk("R2 reset valid", 256'(out_valid), 256'd0);
    chk("R11 reset count", 256'(out_count), 256'd0);
    rst_n = 1'b1;

    for (int f = 0; f < 2; f++)
      for (int u = 0; u < 2; u++)
        for (int hi = 0; hi < 3; hi++)
          for (int li = 0; li < 22; li++)
            run(f[0], u[0], hosts[hi], locs[(li + hi) % 2], lens[li]);

    for (int k = 1; k <= 40; k++) begin
      int unsigned l;
      l = (k * 37171 + k * k * 5113) & 32'hFFFFFF;
      run(k[0], k[1], 64'h0000_0000_FFFF_0000 + 64'(k * 4096), 32'h0100_0000 + 32'(k * 16), l);
    end

    // back-to-back requests, each result belongs to its own request (R2)
    @(negedge clk);
    drive(1'b0, 1'b1, 64'h1234_0000, 32'h40, 32'h9000);
    @(negedge clk);
    drive(1'b1, 1'b0, 64'h5678_0000, 32'h80, 32'h7000);
    check_out(1'b0, 1'b1, 64'h1234_0000, 32'h40, 32'h9000);
    @(negedge clk);
    req_valid = 1'b0;
    check_out(1'b1, 1'b0, 64'h5678_0000, 32'h80, 32'h7000);
    @(negedge clk);
    chk("R2 strobe drop b2b", 256'(out_valid), 256'd0);

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule